// File: doc/BRIEF.md
# Packed Variable Logical Right Shifter

This block treats a wide vector as a row of independent 64-bit lanes and moves each lane of a data operand toward its least significant end. The distance comes from the matching lane of a count operand. Vacated high bits are filled with zeros. A broadcast control can apply the low 64-bit count lane to every lane in place of the per-lane counts.

A per-lane write mask can gate the result. In merge mode, a masked-off lane takes the matching lane of a passthrough vector. In zeroing mode, a masked-off lane is written as all zeros. The vector width is set by a parameter to 128, 256 or 512 bits, which gives 2, 4 or 8 lanes. The mask port is always 8 bits wide.

Operands are captured when `in_valid` is high. The result is presented with `out_valid` one clock later.

Top module: `vshr_lanes`

## Requirements
- R1: Each result lane equals the data lane in the same position shifted right by that lane's count, with zeros entering at the top. Lane i occupies bits [64*i+63 : 64*i].
- R2: The full 64-bit count is read as unsigned. Any count of 64 or more yields an all-zero lane.
- R3: A count of zero returns the data lane unchanged, including all-ones data.
- R4: When `bcast_cnt` is 1, bits [63:0] of `cnt_in` serve as the count for every lane, and the other count lanes have no effect.
- R5: When `mask_en` is 0, every lane takes its shift result whatever `mask_in` and `zero_mode` hold.
- R6: When `mask_en` is 1 and `zero_mode` is 0, a lane whose bit `mask_in[i]` is 0 takes lane i of `pass_in`. A lane whose mask bit is 1 takes its shift result.
- R7: When `mask_en` is 1 and `zero_mode` is 1, a lane whose bit `mask_in[i]` is 0 is written as all zeros.
- R8: Mask bits at positions equal to or above the lane count have no effect on the result.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the result of that request is on `res_out` in that cycle. A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid and are captured this cycle |
| data_in | input | VEC_W | Data lanes to be shifted |
| cnt_in | input | VEC_W | Per-lane shift counts; bits [63:0] are the broadcast count |
| pass_in | input | VEC_W | Lanes kept by masked-off lanes in merge mode |
| mask_in | input | 8 | Per-lane write mask, bit i for lane i |
| mask_en | input | 1 | 1 applies the write mask |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges from `pass_in` |
| bcast_cnt | input | 1 | 1 uses the low count lane for all lanes |
| out_valid | output | 1 | Result valid |
| res_out | output | VEC_W | Result lanes |

## Verification
The lane assertions compare the result against inputs sampled one cycle earlier with `$past`. They therefore assume the operands and mode controls are steady and known on the edge where `in_valid` is high. The bench drives every input on the falling edge and holds it through the following rising edge, so each capture sees one complete request. The assertions also assume `in_valid` is low while `rst` is high. The bench keeps `in_valid` low through reset, and it raises reset mid-stream only between requests.

// File: rtl/vshr_pkg.sv
package vshr_pkg;
   localparam int LANE_W = 64;
   localparam int MASK_W = 8;
   localparam int SH_W   = $clog2(LANE_W);

   typedef logic [LANE_W-1:0] lane_t;

   function automatic bit width_ok(input int w);
      return (w == 128) || (w == 256) || (w == 512);
   endfunction
endpackage

// File: rtl/vshr_lane_shift.sv
module vshr_lane_shift
   import vshr_pkg::*;
(
   input  lane_t data_i,
   input  lane_t cnt_i,
   output lane_t res_o
);
   lane_t stg [0:SH_W];
   logic  big;

   assign stg[0] = data_i;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      assign stg[s+1] = cnt_i[s] ? (stg[s] >> (2**s)) : stg[s];
   end

   assign big   = |cnt_i[LANE_W-1:SH_W];
   assign res_o = big ? '0 : stg[SH_W];
endmodule

// File: rtl/vshr_lane_pick.sv
module vshr_lane_pick
   import vshr_pkg::*;
(
   input  lane_t shifted_i,
   input  lane_t pass_i,
   input  logic  keep_i,
   input  logic  mask_en_i,
   input  logic  zero_mode_i,
   output lane_t lane_o
);
   always_comb begin
      if (!mask_en_i || keep_i)
         lane_o = shifted_i;
      else if (zero_mode_i)
         lane_o = '0;
      else
         lane_o = pass_i;
   end
endmodule

// File: rtl/vshr_lanes.sv
module vshr_lanes
   import vshr_pkg::*;
#(
   parameter int VEC_W = 256
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] data_in,
   input  logic [VEC_W-1:0] cnt_in,
   input  logic [VEC_W-1:0] pass_in,
   input  logic [7:0]       mask_in,
   input  logic             mask_en,
   input  logic             zero_mode,
   input  logic             bcast_cnt,
   output logic             out_valid,
   output logic [VEC_W-1:0] res_out
);
   localparam int NLANE = VEC_W / LANE_W;

   if (!width_ok(VEC_W)) begin : g_bad_width
      $error("vshr_lanes: VEC_W must be 128, 256 or 512");
   end

   if (NLANE < MASK_W) begin : g_spare_mask
      logic unused_mask_hi;
      assign unused_mask_hi = ^mask_in[MASK_W-1:NLANE];
   end

   logic [VEC_W-1:0] picked;
   logic [VEC_W-1:0] res_q;
   logic             vld_q;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      lane_t cnt_sel;
      lane_t shifted;

      assign cnt_sel = bcast_cnt ? cnt_in[LANE_W-1:0] : cnt_in[g*LANE_W +: LANE_W];

      vshr_lane_shift u_shift (
         .data_i (data_in[g*LANE_W +: LANE_W]),
         .cnt_i  (cnt_sel),
         .res_o  (shifted)
      );

      vshr_lane_pick u_pick (
         .shifted_i   (shifted),
         .pass_i      (pass_in[g*LANE_W +: LANE_W]),
         .keep_i      (mask_in[g]),
         .mask_en_i   (mask_en),
         .zero_mode_i (zero_mode),
         .lane_o      (picked[g*LANE_W +: LANE_W])
      );

      // R2: an oversize unmasked count empties the lane
      a_r2_big_count_zero: assert property (@(posedge clk) disable iff (rst)
         out_valid && $past(!mask_en && !bcast_cnt &&
                            (cnt_in[g*LANE_W +: LANE_W] >= 64'd64))
         |-> res_out[g*LANE_W +: LANE_W] == '0);

      // R3: a zero count is the identity
      a_r3_zero_count_same: assert property (@(posedge clk) disable iff (rst)
         out_valid && $past(!mask_en && !bcast_cnt &&
                            (cnt_in[g*LANE_W +: LANE_W] == '0))
         |-> res_out[g*LANE_W +: LANE_W] == $past(data_in[g*LANE_W +: LANE_W]));

      // R6: a masked-off lane merges the passthrough value
      a_r6_merge_pass: assert property (@(posedge clk) disable iff (rst)
         out_valid && $past(mask_en && !zero_mode && !mask_in[g])
         |-> res_out[g*LANE_W +: LANE_W] == $past(pass_in[g*LANE_W +: LANE_W]));

      // R7: a masked-off lane is cleared in zeroing mode
      a_r7_zero_lane: assert property (@(posedge clk) disable iff (rst)
         out_valid && $past(mask_en && zero_mode && !mask_in[g])
         |-> res_out[g*LANE_W +: LANE_W] == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid)
            res_q <= picked;
      end
   end

   assign out_valid = vld_q;
   assign res_out   = res_q;

   // R9: one-cycle valid latency
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
endmodule

// File: tb/vshr_lanes_tb.sv
`timescale 1ns/1ps
module vshr_lanes_tb;
   localparam int VEC_W = 256;
   localparam int NL    = VEC_W / 64;

   typedef struct packed {
      logic [VEC_W-1:0] d;
      logic [VEC_W-1:0] c;
      logic [VEC_W-1:0] p;
      logic [7:0]       m;
      logic             men;
      logic             zm;
      logic             bc;
   } vec_t;

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] PAT  = 64'h8123_4567_89AB_CDEF;

   localparam int NT = 9;
   localparam vec_t TBL [0:NT-1] = '{
      '{ {PAT, ONES, 64'h0F0F_0000_F0F0_1234, PAT}, {64'd32, 64'd8, 64'd4, 64'd1},
         '0, 8'h00, 1'b0, 1'b0, 1'b0 },
      '{ {ONES, PAT, ONES, PAT}, '0, '0, 8'h00, 1'b0, 1'b0, 1'b0 },
      '{ {ONES, ONES, ONES, ONES}, {ONES, 64'd65, 64'd64, 64'd63},
         '0, 8'h00, 1'b0, 1'b0, 1'b0 },
      '{ {PAT, ONES, PAT, ONES}, {64'd70, 64'd70, 64'd70, 64'd12},
         '0, 8'h00, 1'b0, 1'b0, 1'b1 },
      '{ {ONES, ONES, ONES, ONES}, {64'd3, 64'd3, 64'd3, 64'd3},
         {64'hAAAA, 64'hBBBB, 64'hCCCC, 64'hDDDD}, 8'h05, 1'b1, 1'b0, 1'b0 },
      '{ {ONES, ONES, ONES, ONES}, {64'd5, 64'd5, 64'd5, 64'd5},
         {64'hAAAA, 64'hBBBB, 64'hCCCC, 64'hDDDD}, 8'h0A, 1'b1, 1'b1, 1'b0 },
      '{ {PAT, PAT, PAT, PAT}, {64'd2, 64'd6, 64'd40, 64'd0},
         {ONES, ONES, ONES, ONES}, 8'h00, 1'b0, 1'b1, 1'b0 },
      '{ {PAT, PAT, PAT, PAT}, {64'd1, 64'd1, 64'd1, 64'd1},
         {64'h1, 64'h2, 64'h3, 64'h4}, 8'hF0, 1'b1, 1'b0, 1'b0 },
      '{ {ONES, ONES, ONES, ONES}, {64'd9, 64'd9, 64'd9, 64'd9},
         '0, 8'h0F, 1'b1, 1'b1, 1'b0 }
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R1";
         1: return "R3";
         2: return "R2";
         3: return "R4";
         4: return "R6";
         5: return "R7";
         6: return "R5";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [VEC_W-1:0] model(input vec_t v);
      logic [VEC_W-1:0] r;
      for (int i = 0; i < NL; i++) begin
         logic [63:0] c, s;
         c = v.bc ? v.c[63:0] : v.c[i*64 +: 64];
         s = (c >= 64) ? 64'd0 : (v.d[i*64 +: 64] >> c);
         if (v.men && !v.m[i])
            s = v.zm ? 64'd0 : v.p[i*64 +: 64];
         r[i*64 +: 64] = s;
      end
      return r;
   endfunction

   logic             clk = 1'b0;
   logic             rst;
   logic             in_valid;
   logic [VEC_W-1:0] data_in, cnt_in, pass_in;
   logic [7:0]       mask_in;
   logic             mask_en, zero_mode, bcast_cnt;
   logic             out_valid;
   logic [VEC_W-1:0] res_out;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   vshr_lanes #(.VEC_W(VEC_W)) u_dut (
      .clk, .rst, .in_valid, .data_in, .cnt_in, .pass_in, .mask_in,
      .mask_en, .zero_mode, .bcast_cnt, .out_valid, .res_out
   );

   task automatic check(input string req, input logic [VEC_W-1:0] act,
                        input logic [VEC_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      data_in = v.d; cnt_in = v.c; pass_in = v.p; mask_in = v.m;
      mask_en = v.men; zero_mode = v.zm; bcast_cnt = v.bc; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; data_in = '0; cnt_in = '0; pass_in = '0;
      mask_in = '0; mask_en = 1'b0; zero_mode = 1'b0; bcast_cnt = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 reset", {{(VEC_W-1){1'b0}}, out_valid}, '0);
      rst = 1'b0;

      for (int i = 0; i < NT; i++) begin
         drive(TBL[i]);
         check({tag_of(i), " valid"}, {{(VEC_W-1){1'b0}}, out_valid}, 1);
         check(tag_of(i), res_out, model(TBL[i]));
      end

      // R9: the valid pulse lasts one cycle
      @(negedge clk);
      check("R9 drop", {{(VEC_W-1){1'b0}}, out_valid}, '0);

      // R2: a count with only high bits set does not wrap
      drive('{ {ONES, ONES, ONES, ONES}, {64'h100, 64'h8000_0000_0000_0001,
               64'h41, 64'h40}, '0, 8'h00, 1'b0, 1'b0, 1'b0 });
      check("R2 high count", res_out, '0);

      // R9: reset mid-stream clears out_valid
      drive(TBL[0]);
      rst = 1'b1;
      @(negedge clk);
      check("R9 reset clear", {{(VEC_W-1){1'b0}}, out_valid}, '0);
      rst = 1'b0;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule